// File: doc/BRIEF.md
# Cache-Miss Replay Log Recorder

This block sits next to one core's private data cache and builds the log that a replayer needs to re-execute that core's instruction stream on its own. A checkpoint request captures a set of architectural register values and the program counter, and the block serialises them into the log. After that, every line fill the cache performs because of a miss produces one log entry. The entry carries the running count of retired memory operations and the data the fill brought in. During replay, loads are answered from these entries, so values that arrive from I/O, DMA or other cores are captured without any record of inter-core ordering.

Store misses log the line data as fetched, which is the value before the store modified it. The replayer can recompute the new value itself. Instruction-fetch misses are logged in the same form as load misses, so code that modifies itself can still be replayed. There is no notion of privilege level in the block, so logging continues in kernel mode. A line refilled after a remote invalidation is just another miss. Entries leave the block on a valid/ready stream through a small FIFO. When the FIFO cannot take another entry, or a checkpoint is being serialised, the block raises a stall request to the core instead of dropping anything.

Top module: `rlog_recorder`

## Requirements
- R1: After reset, `log_valid_o` and `stall_o` are low and the operation count is zero, so a miss logged before any retirement or checkpoint carries tag 0.
- R2: An accepted checkpoint (`ckpt_req_i` high while `stall_o` is low) emits NREG register entries and then one PC entry, before any later miss entry.
  - Register i sits at `ckpt_regs_i[i*DW +: DW]`, and its entry has kind 2'b10 and tag i.
  - The PC entry has kind 2'b11, tag 0 and data `ckpt_pc_i`.
- R3: A fill with `fill_is_store_i` low emits one entry of kind 2'b00 whose data is `fill_data_i` and whose tag is the operation count.
- R4: A fill with `fill_is_store_i` high and `fill_is_fetch_i` low emits kind 2'b01, and its data is `fill_data_i`, the line contents before the store is applied.
- R5: A fill with `fill_is_fetch_i` high is logged as kind 2'b00, whatever the store flag says.
- R6: The operation count rises by one for each cycle in which `op_retire_i` is high, wraps modulo 2^CW, and becomes zero in the cycle after an accepted checkpoint.
- R7: When `op_retire_i` and a fill arrive in the same cycle, the fill's tag already includes that retirement (count + 1).
- R8: `stall_o` is high exactly while checkpoint entries are still waiting to enter the FIFO, or while the FIFO holds DEPTH entries.
  - The core issues no fill, retirement or checkpoint while `stall_o` is high.
  - Every entry comes out once, in the order it was produced.
- R9: While `log_valid_o` is high and `log_ready_i` is low, the presented entry (kind, tag, data) stays unchanged and valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_retire_i | input | 1 | One load or store retired this cycle |
| fill_valid_i | input | 1 | Cache performs a miss fill this cycle |
| fill_data_i | input | DW | Data fetched by the fill, before any store update |
| fill_is_store_i | input | 1 | Fill was caused by a store |
| fill_is_fetch_i | input | 1 | Fill was caused by an instruction fetch |
| ckpt_req_i | input | 1 | Checkpoint request |
| ckpt_regs_i | input | NREG*DW | Register snapshot, register i in slice i |
| ckpt_pc_i | input | DW | Program counter at the checkpoint |
| stall_o | output | 1 | Core must hold off fills, retirements and checkpoints |
| log_valid_o | output | 1 | Log entry presented |
| log_ready_i | input | 1 | Consumer takes the entry |
| log_kind_o | output | 2 | Entry kind: 00 load/fetch miss, 01 store miss, 10 register, 11 PC |
| log_tag_o | output | CW | Operation count, or register index |
| log_data_o | output | DW | Fill data, register value or PC |

## Verification
The recorder is first exercised with plain load misses between retirement strobes. This shows whether the count advances per retirement and whether the tag is taken before or after a retirement in the same cycle. Store, fetch and combined store-plus-fetch fills then show whether the kind code follows the flags with fetch taking precedence. Long stretches with the consumer blocked, and then with pseudo-random readiness, compare the stall request against a reference occupancy model and reveal any lost or reordered entry. Checkpoints are issued both with the output flowing and with it blocked, and a long run of retirements crosses the count wrap. Together these show that register entries precede later misses and that the count restarts at zero.

// File: rtl/rlog_pkg.sv
package rlog_pkg;
  typedef enum logic [1:0] {
    RK_LOAD  = 2'b00,
    RK_STORE = 2'b01,
    RK_REG   = 2'b10,
    RK_PC    = 2'b11
  } rlog_kind_e;
endpackage

// File: rtl/rlog_opcount.sv
module rlog_opcount #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_incl_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    cnt_d  = clr_i ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o      = cnt_q;
  assign cnt_incl_o = cnt_q + CW'(inc_i);
endmodule

// File: rtl/rlog_ckpt_seq.sv
module rlog_ckpt_seq
  import rlog_pkg::*;
#(
  parameter int DW   = 32,
  parameter int CW   = 16,
  parameter int NREG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NREG*DW-1:0] regs_i,
  input  logic [DW-1:0]    pc_i,
  input  logic             full_i,
  output logic             busy_o,
  output logic             push_o,
  output rlog_kind_e       kind_o,
  output logic [CW-1:0]    tag_o,
  output logic [DW-1:0]    data_o
);
  localparam int IW = $clog2(NREG + 1);

  logic          busy_q, busy_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [DW-1:0] regs_q [NREG];
  logic [DW-1:0] pc_q;
  logic [DW-1:0] sel_reg;
  logic          at_pc;

  for (genvar g = 0; g < NREG; g++) begin : g_snap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       regs_q[g] <= '0;
      else if (start_i) regs_q[g] <= regs_i[g*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc_q <= '0;
    else if (start_i) pc_q <= pc_i;
  end

  always_comb begin
    sel_reg = '0;
    for (int i = 0; i < NREG; i++)
      if (idx_q == IW'(i)) sel_reg = regs_q[i];
  end

  assign at_pc  = (idx_q == IW'(NREG));
  assign push_o = busy_q & ~full_i;
  assign busy_o = busy_q;
  assign kind_o = at_pc ? RK_PC : RK_REG;
  assign tag_o  = at_pc ? '0 : CW'(idx_q);
  assign data_o = at_pc ? pc_q : sel_reg;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (start_i) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (push_o) begin
      if (at_pc) busy_d = 1'b0;
      idx_d = idx_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end
endmodule

// File: rtl/rlog_fifo.sv
module rlog_fifo #(
  parameter int W     = 50,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         valid_o,
  output logic         full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          do_push, do_pop;

  assign full_o  = (lvl_q == LW'(DEPTH));
  assign valid_o = (lvl_q != '0);
  assign rdata_o = mem_q[rd_q];
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & valid_o;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    lvl_d = lvl_q;
    if (do_push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
    if (do_pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
    if (do_push && !do_pop) lvl_d = lvl_q + LW'(1);
    if (!do_push && do_pop) lvl_d = lvl_q - LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             mem_q[g] <= '0;
      else if (do_push && wr_q == PW'(g))     mem_q[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/rlog_recorder.sv
module rlog_recorder
  import rlog_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CW    = 16,
  parameter int NREG  = 4,
  parameter int DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_retire_i,
  input  logic               fill_valid_i,
  input  logic [DW-1:0]      fill_data_i,
  input  logic               fill_is_store_i,
  input  logic               fill_is_fetch_i,
  input  logic               ckpt_req_i,
  input  logic [NREG*DW-1:0] ckpt_regs_i,
  input  logic [DW-1:0]      ckpt_pc_i,
  output logic               stall_o,
  output logic               log_valid_o,
  input  logic               log_ready_i,
  output logic [1:0]         log_kind_o,
  output logic [CW-1:0]      log_tag_o,
  output logic [DW-1:0]      log_data_o
);
  localparam int EW = 2 + CW + DW;

  logic          start, miss_push, fifo_full, seq_busy, seq_push;
  logic [CW-1:0] cnt_q, cnt_incl, seq_tag;
  logic [DW-1:0] seq_data;
  rlog_kind_e    seq_kind, miss_kind;
  logic [EW-1:0] wr_entry, rd_entry;

  assign stall_o   = seq_busy | fifo_full;
  assign start     = ckpt_req_i & ~stall_o;
  assign miss_push = fill_valid_i & ~stall_o;
  assign miss_kind = (fill_is_store_i & ~fill_is_fetch_i) ? RK_STORE : RK_LOAD;

  rlog_opcount #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (start),
    .inc_i      (op_retire_i),
    .cnt_o      (cnt_q),
    .cnt_incl_o (cnt_incl)
  );

  rlog_ckpt_seq #(.DW(DW), .CW(CW), .NREG(NREG)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .regs_i  (ckpt_regs_i),
    .pc_i    (ckpt_pc_i),
    .full_i  (fifo_full),
    .busy_o  (seq_busy),
    .push_o  (seq_push),
    .kind_o  (seq_kind),
    .tag_o   (seq_tag),
    .data_o  (seq_data)
  );

  always_comb begin
    if (seq_push) wr_entry = {seq_kind, seq_tag, seq_data};
    else          wr_entry = {miss_kind, cnt_incl, fill_data_i};
  end

  rlog_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (seq_push | miss_push),
    .wdata_i (wr_entry),
    .pop_i   (log_ready_i),
    .rdata_o (rd_entry),
    .valid_o (log_valid_o),
    .full_o  (fifo_full)
  );

  assign log_kind_o = rd_entry[EW-1 -: 2];
  assign log_tag_o  = rd_entry[DW +: CW];
  assign log_data_o = rd_entry[DW-1:0];
endmodule

// File: rtl/rlog_recorder_chk.sv
module rlog_recorder_chk #(
  parameter int DW   = 32,
  parameter int CW   = 16,
  parameter int NREG = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_retire_i,
  input logic          fill_valid_i,
  input logic          ckpt_req_i,
  input logic          stall_o,
  input logic          log_valid_o,
  input logic          log_ready_i,
  input logic [1:0]    log_kind_o,
  input logic [CW-1:0] log_tag_o,
  input logic [DW-1:0] log_data_o,
  input logic [CW-1:0] cnt_q
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_retire_i && !(ckpt_req_i && !stall_o)) |=> cnt_q == $past(cnt_q) + CW'(1)); // R6

  AST_CKPT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ckpt_req_i && !stall_o) |=> (cnt_q == '0 && stall_o)); // R2

  AST_ENTRY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid_o && !log_ready_i) |=> (log_valid_o && $stable(log_kind_o)
      && $stable(log_tag_o) && $stable(log_data_o))); // R9

  AST_NO_FILL_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> !fill_valid_i); // R8

  AST_REG_TAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid_o && log_kind_o == 2'b10) |-> log_tag_o < CW'(NREG)); // R2
endmodule

bind rlog_recorder rlog_recorder_chk #(.DW(DW), .CW(CW), .NREG(NREG)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_retire_i  (op_retire_i),
  .fill_valid_i (fill_valid_i),
  .ckpt_req_i   (ckpt_req_i),
  .stall_o      (stall_o),
  .log_valid_o  (log_valid_o),
  .log_ready_i  (log_ready_i),
  .log_kind_o   (log_kind_o),
  .log_tag_o    (log_tag_o),
  .log_data_o   (log_data_o),
  .cnt_q        (cnt_q)
);

// File: tb/rlog_recorder_bench.sv
module rlog_recorder_bench;
  localparam int DW    = 32;
  localparam int CW    = 16;
  localparam int NREG  = 4;
  localparam int DEPTH = 4;
  localparam int EW    = 2 + CW + DW;

  logic               clk;
  logic               rst_n;
  logic               op_retire_i, fill_valid_i, fill_is_store_i, fill_is_fetch_i;
  logic [DW-1:0]      fill_data_i;
  logic               ckpt_req_i;
  logic [NREG*DW-1:0] ckpt_regs_i;
  logic [DW-1:0]      ckpt_pc_i;
  logic               stall_o, log_valid_o, log_ready_i;
  logic [1:0]         log_kind_o;
  logic [CW-1:0]      log_tag_o;
  logic [DW-1:0]      log_data_o;

  rlog_recorder #(.DW(DW), .CW(CW), .NREG(NREG), .DEPTH(DEPTH)) u_rlog_recorder (
    .clk(clk), .rst_n(rst_n), .op_retire_i(op_retire_i), .fill_valid_i(fill_valid_i),
    .fill_data_i(fill_data_i), .fill_is_store_i(fill_is_store_i),
    .fill_is_fetch_i(fill_is_fetch_i), .ckpt_req_i(ckpt_req_i),
    .ckpt_regs_i(ckpt_regs_i), .ckpt_pc_i(ckpt_pc_i), .stall_o(stall_o),
    .log_valid_o(log_valid_o), .log_ready_i(log_ready_i), .log_kind_o(log_kind_o),
    .log_tag_o(log_tag_o), .log_data_o(log_data_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [EW-1:0] exp_q [$];
  int            lvl_m = 0;
  int            busy_left = 0;
  logic [CW-1:0] cnt_m = '0;
  logic [31:0]   seed = 32'h1234_5678;

  function automatic logic [31:0] rnd(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input logic [EW-1:0] act,
                       input logic [EW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: check state, drive inputs, advance the reference model
  task automatic step(input bit f, input bit st, input bit fe, input logic [DW-1:0] fd,
                      input bit rt, input bit ck, input bit rdy);
    bit fa, ca, ra, popped, pushed;
    logic [EW-1:0] e;
    string req;
    @(negedge clk);
    check(stall_o === ((busy_left > 0) || (lvl_m == DEPTH)), "R8 stall",
          EW'(stall_o), EW'((busy_left > 0) || (lvl_m == DEPTH)));
    check(log_valid_o === (lvl_m > 0), "R9 valid", EW'(log_valid_o), EW'(lvl_m > 0));
    fa = f && !stall_o;
    ca = ck && !stall_o && !fa;
    ra = rt && !stall_o && !ca;
    seed = rnd(seed);
    op_retire_i = ra; fill_valid_i = fa; fill_is_store_i = st; fill_is_fetch_i = fe;
    fill_data_i = fd; ckpt_req_i = ca; log_ready_i = rdy;
    for (int i = 0; i < NREG; i++) ckpt_regs_i[i*DW +: DW] = seed ^ DW'(i * 32'h0101_0101);
    ckpt_pc_i = ~seed;
    popped = 0; pushed = 0;
    if (lvl_m > 0 && rdy) begin
      e = exp_q.pop_front();
      req = (e[EW-1 -: 2] >= 2) ? "R2 ckpt entry" : (e[EW-1 -: 2] == 1) ? "R4 store entry" : "R3 miss entry";
      check({log_kind_o, log_tag_o, log_data_o} === e, req, {log_kind_o, log_tag_o, log_data_o}, e);
      popped = 1;
    end
    if (busy_left > 0 && lvl_m < DEPTH) begin
      busy_left--;
      pushed = 1;
    end
    if (fa) begin
      exp_q.push_back({(st && !fe) ? 2'b01 : 2'b00, cnt_m + CW'(ra), fd});
      pushed = 1;
    end
    if (ca) begin
      for (int i = 0; i < NREG; i++) exp_q.push_back({2'b10, CW'(i), ckpt_regs_i[i*DW +: DW]});
      exp_q.push_back({2'b11, CW'(0), ckpt_pc_i});
      busy_left = NREG + 1;
      cnt_m = '0;
    end else begin
      cnt_m = cnt_m + CW'(ra);
    end
    lvl_m = lvl_m + int'(pushed) - int'(popped);
  endtask

  initial begin
    rst_n = 1'b0;
    op_retire_i = 0; fill_valid_i = 0; fill_is_store_i = 0; fill_is_fetch_i = 0;
    fill_data_i = '0; ckpt_req_i = 0; ckpt_regs_i = '0; ckpt_pc_i = '0; log_ready_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state, then a miss with no retirement carries tag 0
    check(log_valid_o === 1'b0 && stall_o === 1'b0, "R1 reset", EW'({log_valid_o, stall_o}), '0);
    step(1, 0, 0, 32'hA5A5_0001, 0, 0, 1);
    // R3 plain loads between retirements
    for (int i = 0; i < 6; i++) step(i % 2 == 0, 0, 0, 32'h1000 + 32'(i), 1, 0, 1);
    // R7 fill with same-cycle retirement
    step(1, 0, 0, 32'hBEEF_0007, 1, 0, 1);
    // R4 store miss, R5 fetch miss and fetch with store flag
    step(1, 1, 0, 32'h5707_0004, 1, 0, 1);
    step(1, 0, 1, 32'hF0F0_0005, 0, 0, 1);
    step(1, 1, 1, 32'hF1F1_0005, 1, 0, 1);
    // R2 checkpoint with output flowing, misses follow
    step(0, 0, 0, '0, 0, 1, 1);
    for (int i = 0; i < 12; i++) step(1, i % 3 == 0, 0, 32'h2000 + 32'(i), i % 2 == 1, 0, 1);
    // R8 output blocked: fill until stall, then release
    for (int i = 0; i < 10; i++) step(1, 0, 0, 32'h3000 + 32'(i), 1, 0, 0);
    // R2 checkpoint requested while blocked, then random readiness
    step(0, 0, 0, '0, 0, 1, 1);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 32'h3100 + 32'(i), 0, 0, 0);
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r = rnd(seed ^ 32'(i));
      step(r[0], r[1], r[2], r, r[3], r[9:4] == 0, r[10] | r[11]);
    end
    // R6 count wraps after 2^CW retirements
    step(0, 0, 0, '0, 0, 1, 1);
    for (int i = 0; i < (1 << CW) + 3; i++) step(0, 0, 0, '0, 1, 0, 1);
    step(1, 0, 0, 32'hCAFE_0006, 0, 0, 1);
    for (int i = 0; i < 20; i++) step(0, 0, 0, '0, 0, 0, 1);
    check(exp_q.size() == 0 && lvl_m == 0, "R8 drained", EW'(exp_q.size()), '0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule